// File: doc/BRIEF.md
# Soft-Start Reference Staircase

This block generates the digital code that a reference DAC turns into the error-amplifier setpoint while a buck converter starts up. When the converter is enabled and its supply is reported healthy, the code climbs from zero to full scale one LSB at a time. Each level is held for a fixed number of switching periods. Because of this, the total ramp time tracks whatever switching frequency the oscillator runs at, whether free-running, resistor-adjusted or synchronized.

The oscillator supplies a one-clock strobe per switching period, and the block counts those strobes. With the default configuration there are 64 levels, each about 9.5 mV in the analog domain, from 0 V to the 0.6 V final reference. Each level lasts 32 strobes, so the full ramp is 2048 switching periods, about 8 ms at 250 kHz. When the last level has served its full hold, a done flag rises.

Dropping either the enable or the supply-good flag clears the code, the strobe counter and the done flag. Once both are high again, a fresh ramp starts from zero.

Top module: `softstart_ramp`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `ref_code` is 0 and `ramp_done` is 0.
- R2: While `en` and `uv_ok` are both high, `ref_code` equals floor(k/32) after k accepted strobes, for k up to 2047. Each strobe is a one-clock high pulse on `cyc_tick`, and its effect is visible after the rising clock edge that samples it.
- R3: A clock edge with `cyc_tick` low changes neither `ref_code` nor `ramp_done`.
- R4: `ref_code` saturates at 63. `ramp_done` rises on the 2048th accepted strobe and stays high, with the code at 63, through any further strobes while the block is enabled.
- R5: An edge that samples `en` low clears `ref_code`, the strobe count and `ramp_done`. This holds even when `cyc_tick` is high at that same edge.
- R6: An edge that samples `uv_ok` low clears `ref_code`, the strobe count and `ramp_done`, in the same way as R5.
- R7: After a clear, a new ramp starts from zero with an empty strobe count, so the first increment needs a full 32 strobes.
- R8: Strobes that arrive while `en` or `uv_ok` is low have no effect: `ref_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable level |
| uv_ok | input | 1 | Input supply above its undervoltage threshold |
| cyc_tick | input | 1 | One-clock strobe per switching period |
| ref_code | output | 6 | Reference DAC code, 0 to 63 |
| ramp_done | output | 1 | High once the final level has been held for a full step |

## Verification
A switching strobe and a loss of enable or supply-good can occur in the same clock. In that case the clear must win, and the strobe must not be counted in the next ramp. The bench first drives the ramp past saturation. It then lowers `en` in the very cycle it raises `cyc_tick`, and later repeats this with `uv_ok` in the middle of a step. After each clear it expects a code of zero, and it then needs a full 32 strobes before the first increment. A stray strobe carried over from the clear would show up as an increment one strobe early.

// File: rtl/softstart_ramp.sv
module softstart_ramp #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              uv_ok,
  input  logic              cyc_tick,
  output logic [CODE_W-1:0] ref_code,
  output logic              ramp_done
);
  localparam int              CNT_W    = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  logic [CNT_W-1:0] cyc_cnt;
  logic             run;
  logic             step_end;

  assign run      = en & uv_ok;
  assign step_end = cyc_tick & (cyc_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt   <= '0;
      ref_code  <= '0;
      ramp_done <= 1'b0;
    end else if (!run) begin
      cyc_cnt   <= '0;
      ref_code  <= '0;
      ramp_done <= 1'b0;
    end else if (cyc_tick && !ramp_done) begin
      cyc_cnt <= step_end ? '0 : cyc_cnt + 1'b1;
      if (step_end) begin
        if (ref_code == CODE_TOP) ramp_done <= 1'b1;
        else                      ref_code  <= ref_code + 1'b1;
      end
    end
  end
endmodule

// File: rtl/softstart_ramp_chk.sv
module softstart_ramp_chk #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              uv_ok,
  input logic              cyc_tick,
  input logic [CODE_W-1:0] ref_code,
  input logic              ramp_done
);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R5 R6
  clear_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && uv_ok) |=> (ref_code == '0) && !ramp_done);

  // R3
  freeze_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uv_ok && !cyc_tick) |=> $stable(ref_code) && $stable(ramp_done));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uv_ok) |=> (ref_code == $past(ref_code)) ||
                      (ref_code == $past(ref_code) + 1'b1));

  // R4
  done_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> ref_code == TOP);

  // R4
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && en && uv_ok) |=> ramp_done);
endmodule

bind softstart_ramp softstart_ramp_chk #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .uv_ok(uv_ok), .cyc_tick(cyc_tick),
  .ref_code(ref_code), .ramp_done(ramp_done)
);

// File: tb/test_softstart_ramp.sv
module test_softstart_ramp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       uv_ok = 1'b0;
  logic       cyc_tick = 1'b0;
  logic [5:0] ref_code;
  logic       ramp_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  softstart_ramp i_softstart_ramp (
    .clk(clk), .rst_n(rst_n), .en(en), .uv_ok(uv_ok), .cyc_tick(cyc_tick),
    .ref_code(ref_code), .ramp_done(ramp_done)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    cyc_tick = 1'b1;
    @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  function automatic int exp_code(int k);
    return (k / 32 > 63) ? 63 : k / 32;
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code in reset", ref_code, 0);
    chk("R1 done in reset", ramp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after reset", ref_code, 0);

    uv_ok = 1'b0; en = 1'b1;
    for (int i = 0; i < 40; i++) tick();
    chk("R8 ticks with uv_ok low", ref_code, 0);
    en = 1'b0; uv_ok = 1'b1;
    for (int i = 0; i < 40; i++) tick();
    chk("R8 ticks with en low", ref_code, 0);

    en = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 2100; k++) begin
      tick();
      chk($sformatf("R2 R4 code k=%0d", k), ref_code, exp_code(k));
      chk($sformatf("R4 done k=%0d", k), ramp_done, (k >= 2048) ? 1 : 0);
      if (k % 7 == 0) begin
        repeat (3) @(negedge clk);
        chk($sformatf("R3 frozen code k=%0d", k), ref_code, exp_code(k));
        chk($sformatf("R3 frozen done k=%0d", k), ramp_done, (k >= 2048) ? 1 : 0);
      end
    end

    en = 1'b0; cyc_tick = 1'b1;
    @(negedge clk);
    cyc_tick = 1'b0;
    chk("R5 clear code with tick", ref_code, 0);
    chk("R5 clear done with tick", ramp_done, 0);
    en = 1'b1;
    for (int k = 1; k <= 32; k++) begin
      tick();
      chk($sformatf("R7 restart after en k=%0d", k), ref_code, k / 32);
    end

    for (int i = 0; i < 17; i++) tick();
    uv_ok = 1'b0; cyc_tick = 1'b1;
    @(negedge clk);
    cyc_tick = 1'b0;
    chk("R6 clear code on uv loss", ref_code, 0);
    chk("R6 clear done on uv loss", ramp_done, 0);
    uv_ok = 1'b1;
    for (int k = 1; k <= 64; k++) begin
      tick();
      chk($sformatf("R7 restart after uv k=%0d", k), ref_code, k / 32);
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-ramp reset", ref_code, 0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule